// File: doc/BRIEF.md
# Block-Chained Boot Image Loader

This block runs once after reset. It takes a byte stream from a boot source, which is presented as a valid/ready byte interface. It writes the decoded image into on-chip instruction memory, and only then lets the processor core run. The stream is a chain of blocks. Each block opens with a ten-byte descriptor that gives a destination byte address, a byte count and a set of flags. A normal block is followed by its payload bytes. A fill block carries no payload, and the loader writes zeros across its range by itself. A block may have a count of zero. The chain can be as long as needed, and the block whose final flag is set ends it.

Payload bytes are gathered into 32-bit words with per-byte write enables before they go to memory. As a result, a block may start and end on any byte. Each descriptor has a short checksum. If the checksum does not match, the loader stops for good, raises an error and keeps the core held until the next reset. When the final block has been written, the loader releases the core and presents instruction address zero as the entry point.

Top module: `boot_loader_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `core_run` and `err` are 0, `in_ready` is 1 and `mem_we` is 0.
- R2: A descriptor is ten stream bytes, with byte 0 arriving first. Bytes 0..3 hold the destination byte address, little-endian. Bytes 4..7 hold the byte count, little-endian. Bytes 8..9 hold the flags, little-endian: byte 8 is flags[7:0] and byte 9 is flags[15:8].
- R3: flags[7:1] must equal the checksum, defined as follows: X is the XOR of bytes 0..7 and byte 9, and the checksum is X[6:0] XOR {6'b0, X[7]}. On a mismatch, `err` goes to 1 two cycles after the tenth byte is accepted. From then until reset, `err` stays 1, `in_ready` stays 0 and `core_run` stays 0.
- R4: In a normal block, the payload bytes that follow the descriptor are written one by one to consecutive byte addresses, starting at the destination address.
- R5: Bytes are merged per 32-bit word. Every word a block touches gets exactly one write. `mem_addr` is the byte address divided by 4, `mem_be[k]` enables byte lane k (address mod 4 = k), and lane k sits at `mem_wdata[8k+7:8k]`.
- R6: flags[0] set marks a fill block. It writes zero to each of its count bytes and takes no bytes from the stream, so the next stream byte begins the next descriptor.
- R7: A block whose count is zero writes nothing and goes directly to the next descriptor, or to handoff if it is final.
- R8: Blocks are processed in stream order with no limit on their number. After the block with flags[15] set, `core_run` becomes 1 and stays 1, with `start_pc` equal to 0.
- R9: After handoff, `in_ready` is 0 and the stream has no effect: nothing more is written.
- R10: In the cycle after a descriptor's tenth byte is accepted, `in_ready` is 0 while the descriptor is checked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Boot byte is offered |
| in_data | input | 8 | Boot byte |
| in_ready | output | 1 | Loader accepts the offered byte this cycle |
| mem_we | output | 1 | Instruction-memory word write strobe |
| mem_addr | output | ADDR_W-2 | Word address of the write |
| mem_wdata | output | 32 | Write data, byte lane k in bits 8k+7:8k |
| mem_be | output | 4 | Byte-lane write enables |
| core_run | output | 1 | Core released from reset |
| start_pc | output | ADDR_W | Entry byte address given to the core |
| err | output | 1 | Descriptor checksum failure, sticky |

## Verification
The assertions assume that every destination range fits inside the instruction memory, because the address is reduced to ADDR_W bits and the checks reason about word boundaries within that space. They also assume that the source keeps `in_data` stable while `in_valid` is high and the byte has not yet been taken. The stimulus meets both assumptions: every block lies below address 0x200, and each byte is held from the falling edge on which it is offered until the rising edge that accepts it. Descriptors with bad checksums are sent only in a dedicated run that is followed by reset.

// File: rtl/bl_pkg.sv
package bl_pkg;

  localparam int HDR_BYTES = 10;

  typedef enum logic [2:0] {
    ST_HDR  = 3'd0,
    ST_CHK  = 3'd1,
    ST_DATA = 3'd2,
    ST_DONE = 3'd3,
    ST_ERR  = 3'd4
  } bl_state_e;

  typedef struct packed {
    logic [15:0] flags;
    logic [31:0] count;
    logic [31:0] dest;
  } bl_desc_t;

  // Fold of the XOR over every descriptor byte except byte 8.
  function automatic logic [6:0] desc_sum(input logic [79:0] raw);
    logic [7:0] x;
    x = 8'h00;
    for (int i = 0; i < HDR_BYTES; i++) begin
      if (i != 8) x = x ^ raw[8*i +: 8];
    end
    return x[6:0] ^ {6'b0, x[7]};
  endfunction

  function automatic logic [3:0] lane_bit(input logic [1:0] lane);
    return 4'b0001 << lane;
  endfunction

endpackage

// File: rtl/bl_hdr_parse.sv
module bl_hdr_parse
  import bl_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [7:0]     byte_in,
  output logic           hdr_done,
  output bl_desc_t       desc,
  output logic           sum_ok
);
  localparam int IDX_W = $clog2(HDR_BYTES);

  logic [79:0]      raw_q;
  logic [IDX_W-1:0] idx_q;

  assign hdr_done = take && (idx_q == IDX_W'(HDR_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      idx_q <= '0;
    end else if (take) begin
      raw_q <= {byte_in, raw_q[79:8]};
      idx_q <= hdr_done ? '0 : idx_q + 1'b1;
    end
  end

  assign desc   = raw_q;
  assign sum_ok = (desc_sum(raw_q) == raw_q[71:65]);

endmodule

// File: rtl/bl_packer.sv
module bl_packer #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [7:0]        byte_in,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              last,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be
);
  import bl_pkg::*;

  logic [31:0] buf_q, buf_n;
  logic [3:0]  be_q, be_n;
  logic [1:0]  lane;
  logic        flush;

  assign lane  = byte_addr[1:0];
  assign flush = fire && (last || lane == 2'd3);

  always_comb begin
    buf_n = buf_q;
    buf_n[8*lane +: 8] = byte_in;
    be_n = be_q | lane_bit(lane);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q     <= '0;
      be_q      <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else begin
      mem_we <= 1'b0;
      if (flush) begin
        mem_we    <= 1'b1;
        mem_addr  <= byte_addr[ADDR_W-1:2];
        mem_wdata <= buf_n;
        mem_be    <= be_n;
        buf_q     <= '0;
        be_q      <= '0;
      end else if (fire) begin
        buf_q <= buf_n;
        be_q  <= be_n;
      end
    end
  end

endmodule

// File: rtl/bl_seq.sv
module bl_seq
  import bl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              hdr_done,
  input  bl_desc_t          desc,
  input  logic              sum_ok,
  output logic              in_ready,
  output logic              hdr_take,
  output logic              byte_fire,
  output logic [7:0]        byte_val,
  output logic [ADDR_W-1:0] byte_addr,
  output logic              byte_last,
  output logic              core_run,
  output logic              err
);
  bl_state_e         st_q;
  logic [31:0]       rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic              fill_q;
  logic              fin_q;

  always_comb begin
    in_ready  = (st_q == ST_HDR) || (st_q == ST_DATA && !fill_q);
    hdr_take  = (st_q == ST_HDR) && in_valid;
    byte_fire = (st_q == ST_DATA) && (fill_q || in_valid);
    byte_val  = fill_q ? 8'h00 : in_data;
    byte_addr = addr_q;
    byte_last = (rem_q == 32'd1);
    core_run  = (st_q == ST_DONE);
    err       = (st_q == ST_ERR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_HDR;
      rem_q  <= '0;
      addr_q <= '0;
      fill_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_HDR: if (hdr_done) st_q <= ST_CHK;
        ST_CHK: begin
          if (!sum_ok) begin
            st_q <= ST_ERR;
          end else begin
            addr_q <= desc.dest[ADDR_W-1:0];
            rem_q  <= desc.count;
            fill_q <= desc.flags[0];
            fin_q  <= desc.flags[15];
            if (desc.count == 32'd0) st_q <= desc.flags[15] ? ST_DONE : ST_HDR;
            else                     st_q <= ST_DATA;
          end
        end
        ST_DATA: if (byte_fire) begin
          rem_q  <= rem_q - 32'd1;
          addr_q <= addr_q + 1'b1;
          if (byte_last) begin
            st_q   <= fin_q ? ST_DONE : ST_HDR;
            fill_q <= 1'b0;
          end
        end
        default: st_q <= st_q;
      endcase
    end
  end

endmodule

// File: rtl/boot_loader_top.sv
module boot_loader_top #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  output logic              core_run,
  output logic [ADDR_W-1:0] start_pc,
  output logic              err
);
  import bl_pkg::*;

  logic              hdr_take, hdr_done, sum_ok;
  bl_desc_t          desc;
  logic              byte_fire, byte_last;
  logic [7:0]        byte_val;
  logic [ADDR_W-1:0] byte_addr;

  bl_hdr_parse u_parse (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (hdr_take),
    .byte_in  (in_data),
    .hdr_done (hdr_done),
    .desc     (desc),
    .sum_ok   (sum_ok)
  );

  bl_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .hdr_done  (hdr_done),
    .desc      (desc),
    .sum_ok    (sum_ok),
    .in_ready  (in_ready),
    .hdr_take  (hdr_take),
    .byte_fire (byte_fire),
    .byte_val  (byte_val),
    .byte_addr (byte_addr),
    .byte_last (byte_last),
    .core_run  (core_run),
    .err       (err)
  );

  bl_packer #(.ADDR_W(ADDR_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (byte_fire),
    .byte_in   (byte_val),
    .byte_addr (byte_addr),
    .last      (byte_last),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be)
  );

  // Entry point handed to the core: first instruction-memory byte.
  assign start_pc = '0;

endmodule

// File: rtl/bl_checker.sv
module bl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       mem_we,
  input logic [3:0] mem_be,
  input logic       core_run,
  input logic       err,
  input logic       hdr_done,
  input logic       sum_ok,
  input logic       byte_fire,
  input logic       byte_last
);
  p_hdr_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |=> !in_ready);

  p_bad_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hdr_done) && !sum_ok) |=> err);

  p_err_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && !in_ready && !core_run));

  p_last_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_fire && byte_last) |=> mem_we);

  p_lane_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_be != 4'b0000));

  p_run_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |=> core_run);

  p_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |-> !in_ready);

  p_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |=> !mem_we);

endmodule

bind boot_loader_top bl_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .mem_we    (mem_we),
  .mem_be    (mem_be),
  .core_run  (core_run),
  .err       (err),
  .hdr_done  (hdr_done),
  .sum_ok    (sum_ok),
  .byte_fire (byte_fire),
  .byte_last (byte_last)
);

// File: tb/boot_loader_top_tb.sv
module boot_loader_top_tb;
  localparam int ADDR_W = 12;
  localparam int MEMB   = 1 << ADDR_W;
  localparam int NB     = 6;

  // Block table: destination, count, fill flag, final flag.
  localparam logic [31:0] T_DEST [NB] = '{32'h000, 32'h013, 32'h021, 32'h030, 32'h041, 32'h100};
  localparam logic [31:0] T_CNT  [NB] = '{32'd8,   32'd6,   32'd2,   32'd0,   32'd9,   32'd5};
  localparam logic        T_FILL [NB] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic        T_FIN  [NB] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, mem_we, core_run, err;
  logic [ADDR_W-3:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0] mem_be;
  logic [ADDR_W-1:0] start_pc;

  int total = 0;
  int bad = 0;
  int writes = 0;
  int cycles = 0;
  logic [7:0] model [MEMB];
  logic [7:0] expv  [MEMB];

  always #2.5 clk = ~clk;

  boot_loader_top #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .core_run(core_run),
    .start_pc(start_pc), .err(err)
  );

  // Memory model, sampled away from the active edge.
  always @(negedge clk) begin
    if (mem_we) begin
      writes++;
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) model[{mem_addr, 2'(k)}] = mem_wdata[8*k +: 8];
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, got cycles=%0d expected fewer", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, got, want);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_desc(input logic [31:0] dest, input logic [31:0] cnt,
                           input logic fill, input logic fin, input logic corrupt);
    logic [7:0] hb [10];
    logic [7:0] x;
    for (int i = 0; i < 4; i++) begin
      hb[i]   = dest[8*i +: 8];
      hb[4+i] = cnt[8*i +: 8];
    end
    hb[9] = {fin, 7'b0};
    x = 8'h00;
    for (int i = 0; i < 10; i++) if (i != 8) x ^= hb[i];
    hb[8] = {(x[6:0] ^ {6'b0, x[7]}) ^ {6'b0, corrupt}, fill};
    for (int i = 0; i < 10; i++) send_byte(hb[i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 core_run in reset", 32'(core_run), 0);
    check("R1 in_ready in reset", 32'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 core_run after reset", 32'(core_run), 0);
    check("R1 err after reset", 32'(err), 0);
    check("R1 in_ready after reset", 32'(in_ready), 1);
    check("R1 mem_we after reset", 32'(mem_we), 0);
  endtask

  initial begin
    int w0, nwords;
    for (int a = 0; a < MEMB; a++) begin model[a] = 8'hEE; expv[a] = 8'hEE; end
    do_reset();

    // Table walk: R2 R4 R5 R6 R7 R8.
    for (int b = 0; b < NB; b++) begin
      w0 = writes;
      send_desc(T_DEST[b], T_CNT[b], T_FILL[b], T_FIN[b], 1'b0);
      for (int j = 0; j < int'(T_CNT[b]); j++) begin
        logic [7:0] v;
        v = T_FILL[b] ? 8'h00 : 8'(16 * b + 1 + j);
        expv[T_DEST[b] + j] = v;
        if (!T_FILL[b]) send_byte(v);
      end
      repeat (int'(T_CNT[b]) + 4) @(negedge clk);
      nwords = (T_CNT[b] == 0) ? 0 :
               int'(((T_DEST[b] + T_CNT[b] - 1) >> 2) - (T_DEST[b] >> 2)) + 1;
      check(T_FILL[b] ? "R6 fill word writes" :
            (T_CNT[b] == 0) ? "R7 zero-count writes" : "R5 word writes per block",
            32'(writes - w0), 32'(nwords));
    end
    begin
      int mism = 0;
      for (int a = 0; a < 512; a++) if (model[a] !== expv[a]) mism++;
      check("R4 image bytes mismatching", 32'(mism), 0);
    end
    check("R8 core_run after final", 32'(core_run), 1);
    check("R8 start_pc", 32'(start_pc), 0);
    check("R8 err clear", 32'(err), 0);

    // R9: stream offered after handoff is not taken.
    w0 = writes;
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h5A;
    repeat (6) @(negedge clk);
    check("R9 in_ready after handoff", 32'(in_ready), 0);
    in_valid = 1'b0;
    check("R9 writes after handoff", 32'(writes - w0), 0);

    // R3: corrupted descriptor.
    do_reset();
    send_desc(32'h080, 32'd4, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    check("R10 stall after descriptor", 32'(in_ready), 0);
    @(negedge clk);
    check("R3 err on bad sum", 32'(err), 1);
    repeat (4) @(negedge clk);
    check("R3 err sticky", 32'(err), 1);
    check("R3 core held", 32'(core_run), 0);
    check("R3 in_ready low", 32'(in_ready), 0);

    // R7 R8: lone final block with zero count.
    do_reset();
    w0 = writes;
    send_desc(32'h000, 32'd0, 1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check("R7 zero-count final writes", 32'(writes - w0), 0);
    check("R8 handoff after zero final", 32'(core_run), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule